// File: doc/BRIEF.md
# MDIO Batch Access Sequencer

This block runs a short, unattended batch of management accesses toward an MDIO engine. Before a run, a list of ready-made 32-bit access words is written into a small internal list memory. A single start pulse then captures the entry count, the engine clock divider and the spacing between accesses. From that pulse the block works alone:

- It enables the engine through its control register, forcing a zero divider up to one.
- It steps through the list. For each entry it publishes the word in its user-access register with the go bit set, then holds until the engine clears that bit.
- Between accesses it waits the programmed spacing.

After the final access, a long fixed settle period runs. A one-cycle done pulse then ends the batch.

The engine side is a plain handshake. The engine sees the go bit rise and performs the serial transfer. It then pulses an acknowledge, which clears the go bit. Clearing the go bit is how the sequencer observes that the access has completed.

Top module: `mdio_batch_seq`

## Requirements
- R1: After reset, `ctrl_reg` and `uacc_reg` are zero and `busy` and `done` are low.
- R2: One cycle after an accepted `start` (sampled while idle), `ctrl_reg` holds bit 30 set (engine enable), the divider in bits DIV_W-1:0 and zeros elsewhere. `busy` is high from then until the batch ends.
- R3: A `clk_div` of zero is written to the divider field as one. The divider field never reads zero while `busy` is high.
- R4: Entries are issued in ascending index order starting at index 0. Each issued `uacc_reg` is bit 31 (go) set with bits 30:0 taken from the stored entry; the stored bit 31 is disregarded. The go bit is only ever set while `busy` is high.
- R5: Once set, the go bit stays set until a clock edge samples `eng_ack` high, and it clears on that edge. An `eng_ack` sampled while the go bit is already clear changes nothing.
- R6: Between two accesses of a batch, the go bit stays clear for exactly `gap_len` + 2 clock cycles, with `gap_len` captured at start.
- R7: After the last access, `done` rises exactly SETTLE_CYCLES + 1 cycles after the go bit clears. `done` is high for one cycle, and `busy` is low in that cycle.
- R8: An `acc_count` of zero issues no access, keeps `busy` low and raises `done` one cycle after the start is sampled.
- R9: An `acc_count` larger than DEPTH runs exactly DEPTH entries.
- R10: A `start` while `busy` is high is ignored. It does not change `ctrl_reg`, the batch length or the number of `done` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a batch (accepted only when idle) |
| acc_count | input | CNT_W | Number of list entries to run |
| clk_div | input | DIV_W | Engine clock divider; zero is forced to one |
| gap_len | input | GAP_W | Idle cycles inserted between accesses |
| wr_en | input | 1 | List memory write strobe |
| wr_addr | input | IDX_W | List memory write index |
| wr_word | input | 32 | Access word to store |
| eng_ack | input | 1 | Engine completion pulse; clears the go bit |
| ctrl_reg | output | 32 | Engine control word: enable bit 30, divider in low bits |
| uacc_reg | output | 32 | User-access word with go bit 31 |
| busy | output | 1 | Batch in progress |
| done | output | 1 | One-cycle pulse when the batch ends |

## Verification
A table of batches covers the main function with several input patterns:
- a mid-length run with a moderate gap;
- a single access with a zero divider, which separates the zero-divider guard from plain capture;
- a full list with a zero gap, which exposes off-by-one errors in the gap skip path;
- an oversize count, which separates clamping from wrap-around;
- a long gap with a slow engine;
- a zero count.

In every batch, the engine model varies its acknowledge latency. The go-high span therefore shows whether the bit is held by the handshake or dropped on a timer. The stored words alternate their bit 31, so forcing the go bit is told apart from copying the entry. Directed runs add a restart attempt during a batch and a stray acknowledge while idle.

// File: rtl/mdio_batch_pkg.sv
package mdio_batch_pkg;

    localparam int WORD_W = 32;
    localparam int GO_BIT = 31;
    localparam int EN_BIT = 30;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_GAP,
        S_SETTLE
    } seq_state_e;

    // Control word: enable plus a divider that is never zero.
    function automatic logic [WORD_W-1:0] make_ctrl(input logic [WORD_W-1:0] div_ext);
        logic [WORD_W-1:0] r;
        r = (div_ext == '0) ? WORD_W'(1) : div_ext;
        r[EN_BIT] = 1'b1;
        return r;
    endfunction

    // Access word with the go bit forced on.
    function automatic logic [WORD_W-1:0] make_go(input logic [WORD_W-1:0] entry);
        logic [WORD_W-1:0] r;
        r = entry;
        r[GO_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/mdio_batch_list.sv
module mdio_batch_list
    import mdio_batch_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_word;
        end
    end

    assign rd_word = mem[rd_addr];

endmodule

// File: rtl/mdio_batch_timer.sv
module mdio_batch_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Final counted cycle of the window.
    assign expire = (cnt == W'(1));

endmodule

// File: rtl/mdio_batch_regs.sv
module mdio_batch_regs
    import mdio_batch_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_ctrl,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              issue,
    input  logic [WORD_W-1:0] entry,
    input  logic              ack,
    output logic [WORD_W-1:0] ctrl_reg,
    output logic [WORD_W-1:0] uacc_reg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_reg <= '0;
            uacc_reg <= '0;
        end else begin
            if (set_ctrl) begin
                ctrl_reg <= make_ctrl(WORD_W'(div_in));
            end
            if (issue) begin
                uacc_reg <= make_go(entry);
            end else if (ack && uacc_reg[GO_BIT]) begin
                uacc_reg[GO_BIT] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/mdio_batch_seq.sv
module mdio_batch_seq
    import mdio_batch_pkg::*;
#(
    parameter int DEPTH         = 8,
    parameter int DIV_W         = 16,
    parameter int GAP_W         = 8,
    parameter int SETTLE_CYCLES = 200,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  acc_count,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [GAP_W-1:0]  gap_len,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [31:0]       wr_word,
    input  logic              eng_ack,
    output logic [31:0]       ctrl_reg,
    output logic [31:0]       uacc_reg,
    output logic              busy,
    output logic              done
);

    localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
    localparam int TMR_W = (SET_W > GAP_W) ? SET_W : GAP_W;

    seq_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  last_idx;
    logic [GAP_W-1:0]  gap_q;
    logic [CNT_W-1:0]  cnt_eff;
    logic [WORD_W-1:0] entry;
    logic              go_now;
    logic              at_last;
    logic              accept;
    logic              tmr_load;
    logic              tmr_tick;
    logic              tmr_exp;
    logic [TMR_W-1:0]  tmr_val;

    assign cnt_eff  = (acc_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : acc_count;
    assign go_now   = uacc_reg[GO_BIT];
    assign at_last  = (idx == last_idx);
    assign accept   = (state == S_IDLE) && start;
    assign tmr_load = (state == S_WAIT) && !go_now;
    assign tmr_val  = at_last ? TMR_W'(SETTLE_CYCLES) : TMR_W'(gap_q);
    assign tmr_tick = (state == S_GAP) || (state == S_SETTLE);
    assign busy     = (state != S_IDLE);

    mdio_batch_list #(.DEPTH(DEPTH)) u_list (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_word (wr_word),
        .rd_addr (idx),
        .rd_word (entry)
    );

    mdio_batch_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tmr_tick),
        .expire   (tmr_exp)
    );

    mdio_batch_regs #(.DIV_W(DIV_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .set_ctrl (accept),
        .div_in   (clk_div),
        .issue    (state == S_ISSUE),
        .entry    (entry),
        .ack      (eng_ack),
        .ctrl_reg (ctrl_reg),
        .uacc_reg (uacc_reg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            idx      <= '0;
            last_idx <= '0;
            gap_q    <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        gap_q <= gap_len;
                        idx   <= '0;
                        if (cnt_eff == '0) begin
                            done <= 1'b1;
                        end else begin
                            last_idx <= IDX_W'(cnt_eff - 1'b1);
                            state    <= S_ISSUE;
                        end
                    end
                end
                S_ISSUE: state <= S_WAIT;
                S_WAIT: begin
                    if (!go_now) begin
                        if (at_last) begin
                            state <= S_SETTLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= (gap_q == '0) ? S_ISSUE : S_GAP;
                        end
                    end
                end
                S_GAP: begin
                    if (tmr_exp) state <= S_ISSUE;
                end
                S_SETTLE: begin
                    if (tmr_exp) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mdio_batch_chk.sv
module mdio_batch_chk #(
    parameter int DIV_W = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        eng_ack,
    input logic [31:0] ctrl_reg,
    input logic [31:0] uacc_reg,
    input logic        busy,
    input logic        done
);

    p_en_busy_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> ctrl_reg[30]);

    p_div_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ctrl_reg[DIV_W-1:0] != '0));

    p_go_in_batch_r4: assert property (@(posedge clk) disable iff (rst)
        uacc_reg[31] |-> busy);

    p_go_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (uacc_reg[31] && !eng_ack) |=> uacc_reg[31]);

    p_go_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (uacc_reg[31] && eng_ack) |=> !uacc_reg[31]);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_restart_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(ctrl_reg));

endmodule

bind mdio_batch_seq mdio_batch_chk #(.DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .eng_ack  (eng_ack),
    .ctrl_reg (ctrl_reg),
    .uacc_reg (uacc_reg),
    .busy     (busy),
    .done     (done)
);

// File: tb/test_mdio_batch_seq.sv
module test_mdio_batch_seq;

    localparam int DEPTH  = 8;
    localparam int CNT_W  = 4;
    localparam int DIV_W  = 16;
    localparam int GAP_W  = 8;
    localparam int SETTLE = 200;
    localparam int ARR    = DEPTH + 4;
    localparam int NVEC   = 6;

    // Fields: count[31:28], divider[27:12], gap[11:4], ack latency[3:0]
    localparam logic [31:0] VEC [NVEC] = '{
        {4'd3,  16'h0010, 8'd4,  4'd1},
        {4'd1,  16'h0000, 8'd0,  4'd0},
        {4'd8,  16'hFFFF, 8'd0,  4'd2},
        {4'd12, 16'h0002, 8'd1,  4'd1},
        {4'd2,  16'h0005, 8'd20, 4'd5},
        {4'd0,  16'h0007, 8'd3,  4'd1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [CNT_W-1:0] acc_count = '0;
    logic [DIV_W-1:0] clk_div = '0;
    logic [GAP_W-1:0] gap_len = '0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [31:0]      wr_word = '0;
    logic             eng_ack_m = 1'b0;
    logic             ack_force = 1'b0;
    logic             eng_ack;
    logic [31:0]      ctrl_reg;
    logic [31:0]      uacc_reg;
    logic             busy;
    logic             done;

    assign eng_ack = eng_ack_m | ack_force;

    mdio_batch_seq #(
        .DEPTH(DEPTH), .DIV_W(DIV_W), .GAP_W(GAP_W), .SETTLE_CYCLES(SETTLE)
    ) i_mdio_batch_seq (
        .clk(clk), .rst(rst), .start(start), .acc_count(acc_count),
        .clk_div(clk_div), .gap_len(gap_len), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_word(wr_word), .eng_ack(eng_ack),
        .ctrl_reg(ctrl_reg), .uacc_reg(uacc_reg), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    int errors = 0;
    int checks = 0;

    // Engine model and monitor state
    int          ack_lat = 1;
    int          age = 0;
    int          n_acc = 0;
    int          low_run = 0;
    int          done_cnt = 0;
    int          done_dly = 0;
    logic        prev_go = 1'b0;
    logic [31:0] got_w [ARR];
    int          gap_run [ARR];
    int          hi_run [ARR];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int s, input int i);
        return {1'(i % 2), 7'(s + 1), 8'(i * 17), 16'hA5C3 ^ 16'(i * 613)};
    endfunction

    always @(negedge clk) begin
        eng_ack_m = 1'b0;
        if (!rst) begin
            if (uacc_reg[31]) begin
                if (!prev_go) begin
                    if (n_acc > 0 && n_acc < ARR) gap_run[n_acc] = low_run;
                    age = 0;
                end
                if (age == ack_lat) begin
                    eng_ack_m = 1'b1;
                    if (n_acc < ARR) begin
                        got_w[n_acc] = uacc_reg;
                        hi_run[n_acc] = age + 1;
                    end
                    n_acc++;
                end else begin
                    age++;
                end
                low_run = 0;
            end else begin
                low_run++;
            end
            prev_go = uacc_reg[31];
            if (done) begin
                done_cnt++;
                done_dly = low_run;
            end
        end
    end

    task automatic load_list(input int s);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = 3'(i);
            wr_word = pat(s, i);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_case(input int s, input logic [31:0] v);
        int cnt, lat, gap, nexp, d0;
        logic [15:0] div, dfix;
        cnt  = int'(v[31:28]);
        div  = v[27:12];
        gap  = int'(v[11:4]);
        lat  = int'(v[3:0]);
        dfix = (div == 16'h0) ? 16'h1 : div;
        nexp = (cnt > DEPTH) ? DEPTH : cnt;
        load_list(s);
        @(negedge clk);
        n_acc = 0; low_run = 0; ack_lat = lat; d0 = done_cnt;
        start = 1'b1; acc_count = 4'(cnt); clk_div = div; gap_len = 8'(gap);
        @(posedge clk); #5;
        // R2 / R3: control word after accepted start
        chk((div == 16'h0) ? "R3" : "R2", "ctrl_reg", ctrl_reg, {16'h4000, dfix});
        if (cnt == 0) begin
            chk("R8", "done after zero-count start", 32'(done), 32'd1);
            chk("R8", "busy on zero count", 32'(busy), 32'd0);
        end else begin
            chk("R2", "busy after start", 32'(busy), 32'd1);
        end
        @(negedge clk);
        start = 1'b0;
        wait (done_cnt == d0 + 1);
        @(posedge clk); #5;
        chk("R7", "done width", 32'(done), 32'd0);
        chk("R7", "busy after done", 32'(busy), 32'd0);
        chk((cnt > DEPTH) ? "R9" : "R4", "access count", 32'(n_acc), 32'(nexp));
        for (int i = 0; i < nexp && i < ARR; i++) begin
            chk("R4", "issued word", got_w[i], {1'b1, pat(s, i)[30:0]});
            chk("R5", "go high span", 32'(hi_run[i]), 32'(lat + 1));
            if (i > 0) chk("R6", "go low gap", 32'(gap_run[i]), 32'(gap + 2));
        end
        if (nexp > 0) chk("R7", "settle delay", 32'(done_dly), 32'(SETTLE + 2));
        else chk("R8", "no access issued", 32'(n_acc), 32'd0);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] u_save, c_save;
        int d0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #5;
        chk("R1", "ctrl_reg reset", ctrl_reg, 32'h0);
        chk("R1", "uacc_reg reset", uacc_reg, 32'h0);
        chk("R1", "busy reset", 32'(busy), 32'd0);
        chk("R1", "done reset", 32'(done), 32'd0);

        for (int s = 0; s < NVEC; s++) run_case(s, VEC[s]);

        // R10: a second start during a batch is ignored
        load_list(7);
        @(negedge clk);
        n_acc = 0; low_run = 0; ack_lat = 2; d0 = done_cnt;
        start = 1'b1; acc_count = 4'd2; clk_div = 16'h0009; gap_len = 8'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1; acc_count = 4'd1; clk_div = 16'h0033; gap_len = 8'd0;
        @(posedge clk); #5;
        chk("R10", "ctrl_reg after restart", ctrl_reg, 32'h4000_0009);
        @(negedge clk);
        start = 1'b0;
        wait (done_cnt == d0 + 1);
        repeat (5) @(negedge clk);
        chk("R10", "accesses with restart", 32'(n_acc), 32'd2);
        chk("R10", "done pulses with restart", 32'(done_cnt - d0), 32'd1);

        // R5: stray acknowledge while idle
        u_save = uacc_reg;
        c_save = ctrl_reg;
        @(negedge clk);
        ack_force = 1'b1;
        @(negedge clk);
        ack_force = 1'b0;
        @(posedge clk); #5;
        chk("R5", "uacc_reg after idle ack", uacc_reg, u_save);
        chk("R5", "ctrl_reg after idle ack", ctrl_reg, c_save);
        chk("R5", "busy after idle ack", 32'(busy), 32'd0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule